// File: doc/BRIEF.md
# Debug Coprocessor Access Gate

This block sits beside the core's decode of debug coprocessor register moves. It decides whether each access may go ahead or must be refused with an Undefined instruction exception. For each access the core presents:

- a valid strobe;
- a 3-bit class for the target register;
- the direction;
- whether the target register is implemented;
- whether a read names general register 15 as its destination.

The core also supplies the current state:

- the privilege level;
- the Debug-state flag;
- the User-access lock bit, which is bit 12 of the debug status word;
- the two mode-select bits, which are bits [15:14] of that word;
- the top four bits of that word.

One clock later the block gives a verdict, proceed or refuse, together with the register select. When a read targets register 15, it also gives the value to load into the condition flags. The debug registers themselves, the exception entry and the debugger port are outside this block.

The class encoding is as follows: 0 is the ID register, 1 the status register, 2 the transfer register, 3 the communications channel, 4 any other implemented debug register. Values 5, 6 and 7 mean an unsupported encoding or a reserved register. The mode-select bits read 2'b00 for no debug mode, 2'b01 and 2'b11 for halting, and 2'b10 for monitor.

Top module: `dbg_cp_access_gate`

## Requirements
- R1: A verdict appears on `proceed` or `undef` exactly one clock after a cycle with `acc_valid` high, and exactly one of the two is high. After a cycle with `acc_valid` low, both are low.
- R2: An access is refused in every state when any of these holds: its class is 5, 6 or 7; `acc_impl` is low; or it is a write to class 0 (the ID register).
- R3: With `dbg_halted` high, every access not covered by R2 proceeds, whatever the privilege, lock or mode bits.
- R4: In User mode (`priv` low, `dbg_halted` low) with `user_lock` low, these proceed: reads of class 0, reads of class 1, reads and writes of class 2, and reads and writes of class 3. Writes of class 1 and all class 4 accesses are refused.
- R5: In User mode with `user_lock` high, every access is refused.
- R6: In a privileged mode (`priv` high, `dbg_halted` low), these proceed for every value of `mode_sel` and of `user_lock`: reads of class 0, reads and writes of class 1, 2 and 3.
- R7: In a privileged mode, class 4 accesses proceed only when `mode_sel` is 2'b10. They are refused for 2'b00, 2'b01 and 2'b11.
- R8: For a class 1 read that proceeds with `acc_rd15` high, `flag_upd` is high, `flag_val` equals `status_top` as sampled with the access, and `flag_unpred` is low.
- R9: For any other read that proceeds with `acc_rd15` high, `flag_upd` and `flag_unpred` are high and `flag_val` is zero. For writes and for refused accesses, `acc_rd15` has no effect: all three flag outputs are low and zero.
- R10: `reg_sel` carries the access class in the cycle its verdict is proceed, and is zero otherwise.
- R11: While `rst_n` is low at a clock edge, every output is cleared at that edge, even if an access is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_class | input | 3 | Target register class (encoding above) |
| acc_write | input | 1 | 1 for a write to the debug register, 0 for a read |
| acc_impl | input | 1 | Target register is implemented |
| acc_rd15 | input | 1 | A read names general register 15 as its destination |
| priv | input | 1 | 1 in a privileged mode, 0 in User mode |
| dbg_halted | input | 1 | Core is in Debug state |
| user_lock | input | 1 | Status bit 12: User access lock |
| mode_sel | input | 2 | Status bits [15:14]: debug mode select |
| status_top | input | 4 | Top four bits of the status word |
| proceed | output | 1 | Access may proceed |
| undef | output | 1 | Access raises Undefined instruction |
| reg_sel | output | 3 | Class of the access that proceeds |
| flag_upd | output | 1 | Load the condition flags |
| flag_val | output | 4 | Value for the condition flags |
| flag_unpred | output | 1 | The flag value is unpredictable |

## Verification
The only state in this block is the verdict register. A wrong state therefore shows at the ports in the very cycle after the access that caused it, as one of three faults: both verdict lines high, both low, or the wrong line high. A sweep over every combination of privilege, Debug state, lock bit, mode bits, class, direction, implemented flag and register-15 destination compares each verdict, register select and flag output with an independent decision function. Separate directed scenarios cover these cases: idle cycles between accesses, accesses that follow each other with no gap, and a reset that arrives while an access is presented.

// File: rtl/dbg_cp_access_gate.sv
module dbg_cp_access_gate #(
  parameter int CLS_W  = 3,
  parameter int FLAG_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [CLS_W-1:0]  acc_class,
  input  logic              acc_write,
  input  logic              acc_impl,
  input  logic              acc_rd15,
  input  logic              priv,
  input  logic              dbg_halted,
  input  logic              user_lock,
  input  logic [1:0]        mode_sel,
  input  logic [FLAG_W-1:0] status_top,
  output logic              proceed,
  output logic              undef,
  output logic [CLS_W-1:0]  reg_sel,
  output logic              flag_upd,
  output logic [FLAG_W-1:0] flag_val,
  output logic              flag_unpred
);
  localparam logic [CLS_W-1:0] C_ID   = CLS_W'(0);
  localparam logic [CLS_W-1:0] C_STAT = CLS_W'(1);
  localparam logic [CLS_W-1:0] C_XFER = CLS_W'(2);
  localparam logic [CLS_W-1:0] C_COMM = CLS_W'(3);
  localparam logic [CLS_W-1:0] C_OTH  = CLS_W'(4);
  localparam logic [1:0]       MONITOR = 2'b10;

  logic supported, user_ok, priv_ok, allow, rd15_hit, go;

  assign supported = acc_impl && (acc_class <= C_OTH) && !(acc_class == C_ID && acc_write);
  assign user_ok   = !user_lock && (acc_class == C_ID || acc_class == C_XFER ||
                                    acc_class == C_COMM || (acc_class == C_STAT && !acc_write));
  assign priv_ok   = (acc_class != C_OTH) || (mode_sel == MONITOR);
  assign allow     = supported && (dbg_halted || (priv ? priv_ok : user_ok));
  assign go        = acc_valid && allow;
  assign rd15_hit  = go && !acc_write && acc_rd15;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      proceed     <= 1'b0;
      undef       <= 1'b0;
      reg_sel     <= '0;
      flag_upd    <= 1'b0;
      flag_val    <= '0;
      flag_unpred <= 1'b0;
    end else begin
      proceed     <= go;
      undef       <= acc_valid && !allow;
      reg_sel     <= go ? acc_class : '0;
      flag_upd    <= rd15_hit;
      flag_val    <= (rd15_hit && acc_class == C_STAT) ? status_top : '0;
      flag_unpred <= rd15_hit && acc_class != C_STAT;
    end
  end

  a_r1_one_verdict: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> (proceed != undef));
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> (!proceed && !undef));
  a_r2_reserved_refused: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && (acc_class > C_OTH || !acc_impl)) |=> undef);
  a_r3_halted_proceeds: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && dbg_halted && acc_impl && acc_class <= C_OTH && acc_class != C_ID) |=> proceed);
  a_r5_locked_user: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !priv && !dbg_halted && user_lock) |=> undef);
  a_r9_unpred_zero: assert property (@(posedge clk) disable iff (!rst_n)
    flag_unpred |-> (flag_upd && flag_val == '0 && proceed));
  a_r10_sel_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !proceed |-> reg_sel == '0);
endmodule

// File: tb/tb_dbg_cp_access_gate.sv
module tb_dbg_cp_access_gate;
  logic clk = 1'b0, rst_n = 1'b0;
  logic acc_valid = 0, acc_write = 0, acc_impl = 0, acc_rd15 = 0;
  logic priv = 0, dbg_halted = 0, user_lock = 0;
  logic [2:0] acc_class = 0;
  logic [1:0] mode_sel = 0;
  logic [3:0] status_top = 0;
  logic proceed, undef, flag_upd, flag_unpred;
  logic [2:0] reg_sel;
  logic [3:0] flag_val;
  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  dbg_cp_access_gate dut (.*);

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic bit ref_allow(input logic [2:0] c, input logic w, input logic im,
                                   input logic p, input logic h, input logic lk, input logic [1:0] m);
    if (!im || c > 3'd4 || (c == 3'd0 && w)) return 0;
    if (h) return 1;
    if (!p) begin
      if (lk) return 0;
      return (c == 3'd0) || (c == 3'd2) || (c == 3'd3) || (c == 3'd1 && !w);
    end
    if (c == 3'd4) return m == 2'b10;
    return 1;
  endfunction

  function automatic string ref_tag(input logic [2:0] c, input logic w, input logic im,
                                    input logic p, input logic h, input logic lk);
    if (!im || c > 3'd4 || (c == 3'd0 && w)) return "R2";
    if (h) return "R3";
    if (!p) return lk ? "R5" : "R4";
    return (c == 3'd4) ? "R7" : "R6";
  endfunction

  task automatic present(input logic [2:0] c, input logic w, input logic im, input logic r15,
                         input logic p, input logic h, input logic lk, input logic [1:0] m,
                         input logic [3:0] st);
    acc_valid = 1; acc_class = c; acc_write = w; acc_impl = im; acc_rd15 = r15;
    priv = p; dbg_halted = h; user_lock = lk; mode_sel = m; status_top = st;
  endtask

  task automatic t_reset_state;
    present(3'd1, 0, 1, 1, 1, 1, 0, 2'b10, 4'hF);
    @(negedge clk);
    chk("R11", "proceed in reset", proceed, 0);
    chk("R11", "undef in reset", undef, 0);
    chk("R11", "flag_upd in reset", flag_upd, 0);
    chk("R11", "reg_sel in reset", reg_sel, 0);
    acc_valid = 0;
    rst_n = 1;
    @(negedge clk);
    chk("R1", "idle proceed", proceed, 0);
    chk("R1", "idle undef", undef, 0);
  endtask

  task automatic t_sweep;
    for (int i = 0; i < 2048; i++) begin
      logic [2:0] c = i[2:0];
      logic w = i[3], im = i[4], r15 = i[5], p = i[6], h = i[7], lk = i[8];
      logic [1:0] m = i[10:9];
      logic [3:0] st = 4'(i * 7 + 3);
      bit a = ref_allow(c, w, im, p, h, lk, m);
      string tg = ref_tag(c, w, im, p, h, lk);
      bit rd = a && !w && r15;
      present(c, w, im, r15, p, h, lk, m, st);
      @(negedge clk);
      chk(tg, "proceed", proceed, int'(a));
      chk(tg, "undef", undef, int'(!a));
      chk("R10", "reg_sel", reg_sel, a ? int'(c) : 0);
      chk(rd && c == 3'd1 ? "R8" : "R9", "flag_upd", flag_upd, int'(rd));
      chk(rd && c == 3'd1 ? "R8" : "R9", "flag_val", flag_val, (rd && c == 3'd1) ? int'(st) : 0);
      chk("R9", "flag_unpred", flag_unpred, int'(rd && c != 3'd1));
    end
  endtask

  task automatic t_gaps;
    present(3'd4, 0, 1, 0, 1, 0, 0, 2'b10, 4'h0);
    @(negedge clk);
    chk("R7", "monitor other proceeds", proceed, 1);
    acc_valid = 0;
    @(negedge clk);
    chk("R1", "gap proceed low", proceed, 0);
    chk("R1", "gap undef low", undef, 0);
    chk("R10", "gap reg_sel zero", reg_sel, 0);
    present(3'd4, 1, 1, 0, 1, 0, 0, 2'b01, 4'h0);
    @(negedge clk);
    chk("R7", "halting other refused", undef, 1);
    present(3'd1, 0, 1, 1, 1, 0, 0, 2'b00, 4'hA);
    @(negedge clk);
    chk("R8", "flags from status", flag_val, 4'hA);
    chk("R1", "back-to-back proceed", proceed, 1);
  endtask

  task automatic t_midreset;
    present(3'd2, 1, 1, 0, 1, 0, 0, 2'b00, 4'h0);
    @(negedge clk);
    chk("R6", "transfer write proceeds", proceed, 1);
    rst_n = 0;
    @(negedge clk);
    chk("R11", "reset clears proceed", proceed, 0);
    chk("R11", "reset clears reg_sel", reg_sel, 0);
    rst_n = 1;
    acc_valid = 0;
    @(negedge clk);
    chk("R1", "after reset idle", proceed | undef, 0);
  endtask

  initial begin
    fork
      begin
        @(negedge clk);
        t_reset_state();
        t_sweep();
        t_gaps();
        t_midreset();
      end
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule